// File: doc/BRIEF.md
# Single-Channel DMA Controller

This block copies a programmed number of bytes without the processor handling the data. It supports three copy paths: device to memory, memory to device, and memory to memory. Software first writes a source address, a destination address and a byte count. It then writes the control register with a path code, a bus-release policy and the start bit. The channel asks for the system bus with a request line and waits for the grant. It then drives a simple synchronous memory bus: a read strobe returns data on the next cycle, and a write strobe is a single cycle. On the device side it uses a ready/acknowledge handshake.

In cycle-stealing mode the channel gives the bus back after every byte, so its accesses interleave with the processor's. In burst mode it keeps the bus until the whole count is done. When the count runs out, a sticky interrupt is raised. It stays set until software writes the status register.

Register select codes are: 0 control, 1 source address, 2 destination address, 3 byte count, 4 status. Control bits are: bit 0 start, bits 2:1 path, bit 3 burst. The path codes are: 0 device to memory (writes memory at the destination address), 1 memory to device (reads memory at the source address), 2 or 3 memory to memory. Reading the status register returns bit 0 interrupt and bit 1 busy. Reading the other select codes returns the programmed values.

Top module: `dma_chan`

## Requirements
- R1: After reset, bus request, interrupt, busy and every memory or device strobe are low, and the status register reads 0.
- R2: Path code 0 writes each byte taken from the device into memory at ascending addresses starting at the destination address. It moves exactly the programmed count, and each byte is written in the same cycle as its device acknowledge.
- R3: Path code 1 reads memory at ascending addresses starting at the source address. It hands each byte to the device with an acknowledge on the cycle after the read, or later if the device is not ready.
- R4: Path codes 2 and 3 copy each byte by a memory read at the source address followed by a memory write of that data at the destination address. Both addresses step up by one per byte.
- R5: A memory read strobe, a memory write strobe or a device acknowledge is only driven while bus request and bus grant are both high.
- R6: Once raised, bus request stays high until grant is seen.
- R7: With burst at 0, bus request drops after every byte, so a transfer of N bytes raises bus request N times.
- R8: With burst at 1, bus request rises once and stays high until the last byte is done, even while the device stalls.
- R9: A device acknowledge is only given in a cycle where device ready is high.
- R10: The interrupt rises when the count runs out and stays set until a status write with bit 0 set. A status write with bit 0 clear leaves it set.
- R11: A start with a programmed count of 0 raises the interrupt without ever asserting bus request.
- R12: While busy, control writes (including a start) are ignored, and address or count writes do not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for cfg_sel_i |
| irq_o | output | 1 | Completion interrupt, sticky |
| busy_o | output | 1 | Transfer in progress |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| mem_addr_o | output | 16 | Memory address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after mem_re_o and held until the next read |
| dev_ready_i | input | 1 | Device ready to supply or accept a byte |
| dev_ack_o | output | 1 | Device byte taken or delivered this cycle |
| dev_rdata_i | input | 8 | Byte from device |
| dev_wdata_o | output | 8 | Byte to device, valid with dev_ack_o |

## Verification
All three copy paths are run under both release policies. Counting request edges per transfer tells cycle stealing (one edge per byte) apart from burst (one edge in total). Repeating the transfers with a device that drops ready every few cycles separates a sequencer that waits for the device from one that acknowledges blindly, and shows that burst keeps the bus through stalls. A zero-count start, and a transfer that is disturbed by control, count and start writes while busy, separate a channel that latches its setup from one that reads live registers.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [1:0] DIR_D2M = 2'd0;
  localparam logic [1:0] DIR_M2D = 2'd1;
  localparam logic [1:0] DIR_M2M = 2'd2;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_SRC  = 3'd1;
  localparam logic [2:0] SEL_DST  = 3'd2;
  localparam logic [2:0] SEL_CNT  = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_REQ, ST_XFER, ST_RD, ST_WR, ST_DONE
  } dma_state_e;

  typedef struct packed {
    logic       burst;
    logic [1:0] dir;
  } dma_mode_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             busy_i,
  input  logic             done_i,
  output logic             start_o,
  output dma_mode_t        mode_o,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [CW-1:0]    cnt_o,
  output logic             irq_o,
  output logic [REG_W-1:0] rdata_o
);
  dma_mode_t     mode_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          irq_q;
  logic          clr_w, ctrl_wr;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign ctrl_wr = we_i && (sel_i == SEL_CTRL) && !busy_i;
  assign clr_w   = we_i && (sel_i == SEL_STAT) && wdata_i[0];
  assign start_o = ctrl_wr && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_wr) mode_q <= '{burst: wdata_i[3], dir: wdata_i[2:1]};
      if (we_i && sel_i == SEL_SRC) src_q <= wdata_i[AW-1:0];
      if (we_i && sel_i == SEL_DST) dst_q <= wdata_i[AW-1:0];
      if (we_i && sel_i == SEL_CNT) cnt_q <= wdata_i[CW-1:0];
      if (done_i)     irq_q <= 1'b1;
      else if (clr_w) irq_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_CTRL: rdata_o[3:0]    = {mode_q.burst, mode_q.dir, 1'b0};
      SEL_SRC:  rdata_o[AW-1:0] = src_q;
      SEL_DST:  rdata_o[AW-1:0] = dst_q;
      SEL_CNT:  rdata_o[CW-1:0] = cnt_q;
      SEL_STAT: rdata_o[1:0]    = {busy_i, irq_q};
      default:  rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;

  // R10
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !clr_w |=> irq_q);
  // R12
  mode_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(mode_q));
endmodule

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          step_src_i,
  input  logic          step_dst_i,
  input  logic          step_cnt_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          last_o
);
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      src_q <= src_i;
      dst_q <= dst_i;
      cnt_q <= cnt_i;
    end else begin
      if (step_src_i) src_q <= src_q + 1'b1;
      if (step_dst_i) dst_q <= dst_q + 1'b1;
      if (step_cnt_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign last_o = (cnt_q == CW'(1));

  // R2
  cnt_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_cnt_i |-> cnt_q != '0);
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      cnt_zero_i,
  input  dma_mode_t mode_i,
  input  logic      gnt_i,
  input  logic      dev_ready_i,
  input  logic      last_i,
  output logic      bus_req_o,
  output logic      mem_re_o,
  output logic      mem_we_o,
  output logic      dev_ack_o,
  output logic      sel_dst_o,
  output logic      load_o,
  output logic      step_src_o,
  output logic      step_dst_o,
  output logic      step_cnt_o,
  output logic      done_o,
  output logic      busy_o
);
  dma_state_e st_q, st_d;
  logic d2m, m2m, byte_end;

  assign d2m = (mode_i.dir == DIR_D2M);
  assign m2m = mode_i.dir[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    st_d       = st_q;
    bus_req_o  = 1'b0;
    mem_re_o   = 1'b0;
    mem_we_o   = 1'b0;
    dev_ack_o  = 1'b0;
    sel_dst_o  = 1'b0;
    load_o     = 1'b0;
    step_src_o = 1'b0;
    step_dst_o = 1'b0;
    step_cnt_o = 1'b0;
    done_o     = 1'b0;
    byte_end   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        load_o = 1'b1;
        st_d   = cnt_zero_i ? ST_DONE : ST_ARM;
      end
      // device readiness is awaited off the bus in this state
      ST_ARM: if (m2m || dev_ready_i) st_d = ST_REQ;
      ST_REQ: begin
        bus_req_o = 1'b1;
        if (gnt_i) st_d = d2m ? ST_XFER : ST_RD;
      end
      ST_XFER: begin
        bus_req_o = 1'b1;
        if (gnt_i && dev_ready_i) begin
          mem_we_o   = 1'b1;
          dev_ack_o  = 1'b1;
          sel_dst_o  = 1'b1;
          step_dst_o = 1'b1;
          step_cnt_o = 1'b1;
          byte_end   = 1'b1;
        end
      end
      ST_RD: begin
        bus_req_o = 1'b1;
        if (gnt_i && (m2m || dev_ready_i)) begin
          mem_re_o = 1'b1;
          st_d     = ST_WR;
        end
      end
      ST_WR: begin
        bus_req_o = 1'b1;
        if (gnt_i && m2m) begin
          mem_we_o   = 1'b1;
          sel_dst_o  = 1'b1;
          step_src_o = 1'b1;
          step_dst_o = 1'b1;
          step_cnt_o = 1'b1;
          byte_end   = 1'b1;
        end else if (gnt_i && dev_ready_i) begin
          dev_ack_o  = 1'b1;
          step_src_o = 1'b1;
          step_cnt_o = 1'b1;
          byte_end   = 1'b1;
        end
      end
      ST_DONE: begin
        done_o = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (byte_end) begin
      if (last_i)             st_d = ST_DONE;
      else if (!mode_i.burst) st_d = ST_ARM;
      else                    st_d = d2m ? ST_XFER : ST_RD;
    end
  end

  assign busy_o = (st_q != ST_IDLE);

  // R5
  strobe_in_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o || mem_we_o || dev_ack_o) |-> (bus_req_o && gnt_i));
  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !gnt_i |=> bus_req_o);
  // R9
  dev_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_ack_o |-> dev_ready_i);
  // R7
  steal_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_end && !mode_i.burst |=> !bus_req_o);
  // R8
  burst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_end && mode_i.burst && !last_i |=> bus_req_o);
  // R11
  zero_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) && start_i && cnt_zero_i |=> done_o && !bus_req_o);
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DW    = 8,
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_sel_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  output logic             irq_o,
  output logic             busy_o,
  output logic             bus_req_o,
  input  logic             bus_gnt_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_re_o,
  output logic             mem_we_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             dev_ready_i,
  output logic             dev_ack_o,
  input  logic [DW-1:0]    dev_rdata_i,
  output logic [DW-1:0]    dev_wdata_o
);
  dma_mode_t     mode;
  logic [AW-1:0] cfg_src, cfg_dst, cur_src, cur_dst;
  logic [CW-1:0] cfg_cnt;
  logic start, done, busy, last, load, sel_dst;
  logic step_src, step_dst, step_cnt;

  dma_regs #(.AW(AW), .CW(CW), .REG_W(REG_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .busy_i(busy), .done_i(done), .start_o(start), .mode_o(mode),
    .src_o(cfg_src), .dst_o(cfg_dst), .cnt_o(cfg_cnt),
    .irq_o(irq_o), .rdata_o(cfg_rdata_o)
  );

  dma_ptr #(.AW(AW), .CW(CW)) u_ptr (
    .clk_i, .rst_ni, .load_i(load),
    .src_i(cfg_src), .dst_i(cfg_dst), .cnt_i(cfg_cnt),
    .step_src_i(step_src), .step_dst_i(step_dst), .step_cnt_i(step_cnt),
    .src_o(cur_src), .dst_o(cur_dst), .last_o(last)
  );

  dma_fsm u_fsm (
    .clk_i, .rst_ni, .start_i(start), .cnt_zero_i(cfg_cnt == '0),
    .mode_i(mode), .gnt_i(bus_gnt_i), .dev_ready_i(dev_ready_i),
    .last_i(last), .bus_req_o(bus_req_o), .mem_re_o(mem_re_o),
    .mem_we_o(mem_we_o), .dev_ack_o(dev_ack_o), .sel_dst_o(sel_dst),
    .load_o(load), .step_src_o(step_src), .step_dst_o(step_dst),
    .step_cnt_o(step_cnt), .done_o(done), .busy_o(busy)
  );

  assign mem_addr_o  = sel_dst ? cur_dst : cur_src;
  assign mem_wdata_o = (mode.dir == DIR_D2M) ? dev_rdata_i : mem_rdata_i;
  assign dev_wdata_o = mem_rdata_i;
  assign busy_o      = busy;
endmodule

// File: tb/dma_chan_bench.sv
`timescale 1ns/1ps
module dma_chan_bench;
  import dma_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = SEL_STAT;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq, busy, bus_req, mem_re, mem_we, dev_ack;
  logic        bus_gnt = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, dev_wdata, dev_rdata;
  logic [7:0]  mem_rdata = '0;
  logic        dev_ready;

  always #10 clk = ~clk;

  dma_chan u_dma_chan (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .irq_o(irq),
    .busy_o(busy), .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .dev_ready_i(dev_ready), .dev_ack_o(dev_ack),
    .dev_rdata_i(dev_rdata), .dev_wdata_o(dev_wdata)
  );

  int errors = 0, checks = 0, rises = 0;
  bit finished = 1'b0;
  string cur_tag = "R1";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory stub: synchronous read, data held until next read
  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  // bus grant: two cycles after request, held while requested
  int gwait = 0;
  always @(posedge clk) begin
    if (!bus_req) begin bus_gnt <= 1'b0; gwait <= 0; end
    else if (gwait >= 2) bus_gnt <= 1'b1;
    else gwait <= gwait + 1;
  end

  // device model
  logic [7:0] dev_buf [16];
  int  dev_idx = 0, dev_n = 0, cyc = 0;
  bit  dev_en = 1'b0, dev_sink = 1'b0, stall_en = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (dev_ack && !dev_sink) dev_idx <= dev_idx + 1;
  end
  assign dev_ready = dev_en && !(stall_en && (cyc % 3 == 1)) &&
                     (dev_sink || dev_idx < dev_n);
  assign dev_rdata = dev_buf[dev_idx[3:0]];

  // scoreboard
  logic [23:0] exp_mem_q [$];
  logic [7:0]  exp_dev_q [$];
  logic prev_req = 1'b0, prev_gnt = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (exp_mem_q.size() == 0) chk(1'b0, {cur_tag, " extra mem write"}, int'(mem_addr), -1);
        else begin
          logic [23:0] e;
          e = exp_mem_q.pop_front();
          chk({mem_addr, mem_wdata} == e, {cur_tag, " mem write addr/data"},
              int'({mem_addr, mem_wdata}), int'(e));
        end
      end
      if (dev_ack && dev_sink) begin
        if (exp_dev_q.size() == 0) chk(1'b0, {cur_tag, " extra device byte"}, int'(dev_wdata), -1);
        else begin
          logic [7:0] d;
          d = exp_dev_q.pop_front();
          chk(dev_wdata == d, {cur_tag, " device byte"}, int'(dev_wdata), int'(d));
        end
      end
      if ((mem_re || mem_we || dev_ack) && !(bus_req && bus_gnt))
        chk(1'b0, "R5 strobe outside grant", 1, 0);
      if (dev_ack && !dev_ready) chk(1'b0, "R9 ack without ready", 1, 0);
      if (prev_req && !prev_gnt && !bus_req) chk(1'b0, "R6 request withdrawn", 0, 1);
      if (bus_req && !prev_req) rises++;
      prev_req = bus_req;
      prev_gnt = bus_gnt;
    end
  end

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = SEL_STAT;
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'(seed + i * 37);
  endfunction

  task automatic run(input logic [1:0] dir, input bit burst, input int src,
                     input int dst, input int n, input bit stall, input bit poke,
                     input int seed, input string tag);
    int waited;
    cur_tag = tag;
    @(negedge clk);
    dev_idx = 0; dev_n = 0; dev_sink = (dir == DIR_M2D); stall_en = stall;
    for (int i = 0; i < n; i++) begin
      if (dir == DIR_D2M) begin
        dev_buf[i] = pat(i, seed); dev_n = n;
        exp_mem_q.push_back({16'(dst + i), pat(i, seed)});
      end else begin
        mem[8'(src + i)] = pat(i, seed);
        if (dir == DIR_M2D) exp_dev_q.push_back(pat(i, seed));
        else exp_mem_q.push_back({16'(dst + i), pat(i, seed)});
      end
    end
    dev_en = 1'b1;
    cfg_write(SEL_SRC, 32'(src));
    cfg_write(SEL_DST, 32'(dst));
    cfg_write(SEL_CNT, 32'(n));
    rises = 0;
    cfg_write(SEL_CTRL, {28'd0, burst, dir, 1'b1});
    if (poke) begin
      // R12: disturbing writes while busy
      cfg_write(SEL_CTRL, {28'd0, ~burst, DIR_M2M, 1'b1});
      cfg_write(SEL_CNT, 32'd9);
      cfg_write(SEL_DST, 32'h80);
    end
    waited = 0;
    while (!irq && waited < 3000) begin @(negedge clk); waited++; end
    chk(irq == 1'b1, {tag, " R10 interrupt at end"}, int'(irq), 1);
    chk(rises == (n == 0 ? 0 : (burst ? 1 : n)),
        {tag, (n == 0) ? " R11 request count" : (burst ? " R8 request count" : " R7 request count")},
        rises, (n == 0 ? 0 : (burst ? 1 : n)));
    chk(exp_mem_q.size() == 0 && exp_dev_q.size() == 0,
        {tag, " all bytes moved"}, exp_mem_q.size() + exp_dev_q.size(), 0);
    if (dir == DIR_D2M) chk(dev_idx == n, {tag, " R2 device bytes taken"}, dev_idx, n);
    cfg_sel = SEL_CTRL; #1;
    chk(cfg_rdata[3:0] == {burst, dir, 1'b0}, {tag, " R12 control readback"},
        int'(cfg_rdata[3:0]), int'({burst, dir, 1'b0}));
    cfg_sel = SEL_STAT; #1;
    chk(cfg_rdata[1:0] == 2'b01, {tag, " status idle with irq"}, int'(cfg_rdata[1:0]), 1);
    repeat (4) @(negedge clk);
    chk(irq == 1'b1, {tag, " R10 interrupt sticky"}, int'(irq), 1);
    cfg_write(SEL_STAT, 32'd0);
    chk(irq == 1'b1, {tag, " R10 clear with bit0 low ignored"}, int'(irq), 1);
    cfg_write(SEL_STAT, 32'd1);
    chk(irq == 1'b0, {tag, " R10 interrupt cleared"}, int'(irq), 0);
    dev_en = 1'b0; stall_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_req == 1'b0 && irq == 1'b0 && busy == 1'b0, "R1 outputs in reset", int'({bus_req, irq, busy}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({bus_req, irq, busy, mem_re, mem_we, dev_ack} == '0, "R1 outputs after reset",
        int'({bus_req, irq, busy, mem_re, mem_we, dev_ack}), 0);
    chk(cfg_rdata == '0, "R1 status after reset", int'(cfg_rdata), 0);

    run(DIR_D2M, 1'b1, 0,    8'h20, 5, 1'b0, 1'b0, 3,  "R2 burst");
    run(DIR_D2M, 1'b0, 0,    8'h30, 4, 1'b1, 1'b0, 11, "R2 steal stall R9");
    run(DIR_M2D, 1'b1, 8'h40, 0,    6, 1'b0, 1'b0, 17, "R3 burst");
    run(DIR_M2D, 1'b0, 8'h50, 0,    3, 1'b1, 1'b0, 29, "R3 steal stall R9");
    run(DIR_M2D, 1'b1, 8'h58, 0,    4, 1'b1, 1'b0, 41, "R3 burst stall R8");
    run(DIR_M2M, 1'b1, 8'h60, 8'hA0, 5, 1'b0, 1'b0, 53, "R4 burst");
    run(DIR_M2M, 1'b0, 8'h70, 8'hB0, 4, 1'b0, 1'b0, 67, "R4 steal");
    run(2'd3,    1'b0, 8'h78, 8'hC0, 2, 1'b0, 1'b0, 71, "R4 code3");
    run(DIR_D2M, 1'b0, 0,    8'h10, 0, 1'b0, 1'b0, 0,  "R11 zero count");
    run(DIR_D2M, 1'b1, 0,    8'h90, 6, 1'b1, 1'b1, 83, "R12 busy writes");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule